// File: doc/BRIEF.md
# Angle-Strobed Park Vector Rotator

This block turns a direct/quadrature sample pair through a digital angle. The angle is a 12-bit unsigned code that spans one whole revolution. A host loads the angle with a strobe pulse: the rising edge of the strobe captures the code, and the falling edge starts a conversion. During the conversion, `busy_o` is high. The latched angle is looked up in a quarter-wave sine table with quadrant folding. The resulting sine and cosine factors are then written into their holding registers on the same clock edge.

Once `busy_o` has fallen, every accepted input sample is multiplied by the held factors. The rotated pair appears one clock later: d' = d·cosφ − q·sinφ and q' = d·sinφ + q·cosφ. The results are rounded back to the sample width and saturated. Input samples offered while the strobe is high or while a conversion is running are not accepted. This lets a controller in a field-oriented drive, or a digital-to-resolver path, change the angle without ever seeing a half-updated factor pair.

Top module: `park_rotator`

## Requirements
- R1: After reset, `busy_o` and `out_valid_o` are 0 and the held factors are those of angle 0 (sine 0, cosine 1.0), so the first sample passes through unchanged.
- R2: The angle is captured on the clock where `strobe_i` is first seen high. Later changes of `angle_i`, including the value present when the strobe falls, have no effect on the loaded angle.
- R3: On the first clock at which `strobe_i` is seen low after an accepted rise, `busy_o` rises. It then stays high for exactly `CONV_CYCLES` clocks.
- R4: The sine and cosine factors change only on the clock at which `busy_o` falls, and they change together. The first sample accepted after that uses the new pair in both outputs.
- R5: A strobe rising edge seen while `busy_o` is high is ignored. No angle is captured, no second conversion follows, and the pending angle completes.
- R6: Factors are signed with `COEF_W-2` fraction bits (1.0 = 16384 at default width), each rounded to nearest from the true sine/cosine. The rotated outputs follow d' = d·cos − q·sin and q' = d·sin + q·cos.
- R7: Quadrant folding is exact. At codes 1024, 2048 and 3072 (90°, 180°, 270°), the output is (−q, d), (−d, −q) and (q, −d) respectively.
- R8: Each output is (sum + 2^(FRAC−1)) arithmetically shifted right by FRAC = `COEF_W-2`. The result is clamped to the range −2^(DATA_W−1) to 2^(DATA_W−1)−1.
- R9: `out_valid_o` is 1 exactly one clock after a clock where `in_valid_i` was 1 while `busy_o` and `strobe_i` were both 0. Otherwise it is 0.
- R10: Only the top 2+`IDX_W` angle bits select the factors; the lower `ANGLE_W-2-IDX_W` bits are ignored (with defaults, codes 1024 and 1027 rotate identically).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Angle load strobe: rise captures, fall starts conversion |
| angle_i | input | ANGLE_W | Unsigned angle code, one turn full scale |
| in_valid_i | input | 1 | Input sample qualifier |
| d_i | input | DATA_W | Signed direct component |
| q_i | input | DATA_W | Signed quadrature component |
| busy_o | output | 1 | High while factors are being loaded |
| out_valid_o | output | 1 | Rotated pair valid |
| d_o | output | DATA_W | Rotated direct component |
| q_o | output | DATA_W | Rotated quadrature component |

## Verification
The bench builds the rotator with 16-bit samples and factors, an 8-bit quarter-table index and `CONV_CYCLES` raised to 6. The longer busy window leaves room to drive a second strobe pulse and gated samples fully inside a conversion. The 8-bit index drops two angle bits, which exposes the quantisation in R10. Full-scale 16-bit operands let the 90° and 180° rotations of −32768 reach the positive clamp.

// File: rtl/park_pkg.sv
// Package: shared state type and the constant sine generator for the
// quarter-wave table. Assumes idx_w <= 30 and coef_w <= 31.
package park_pkg;

    typedef enum logic [1:0] {
        CT_IDLE  = 2'd0,
        CT_ARMED = 2'd1,
        CT_BUSY  = 2'd2
    } ctrl_state_t;

    // Rounded sine of (idx / 2^idx_w) * 90 degrees, scaled so 1.0 = 2^(coef_w-2).
    function automatic int quarter_sine_code(int idx, int idx_w, int coef_w);
        real x;
        real term;
        real acc;
        x    = 1.5707963267948966 * real'(idx) / real'(1 << idx_w);
        acc  = x;
        term = x;
        for (int k = 1; k < 9; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return $rtoi(acc * real'(1 << (coef_w - 2)) + 0.5);
    endfunction

endpackage

// File: rtl/park_sincos_lut.sv
// Module: combinational sine/cosine lookup for an angle code.
// Holds a quarter-wave table with 2^IDX_W+1 entries (0..90 degrees inclusive)
// and folds it into four quadrants. Cosine is read a quarter turn ahead.
// Assumes IDX_W <= ANGLE_W-2; the remaining low angle bits are ignored.
module park_sincos_lut #(
    parameter int ANGLE_W = 12,
    parameter int IDX_W   = 8,
    parameter int COEF_W  = 16
) (
    input  logic [ANGLE_W-1:0]       angle_i,
    output logic signed [COEF_W-1:0] sin_o,
    output logic signed [COEF_W-1:0] cos_o
);
    localparam int N_ENT  = (1 << IDX_W) + 1;
    localparam int LOW_W  = ANGLE_W - 2 - IDX_W;
    localparam logic [IDX_W:0] N_IDX = {1'b1, {IDX_W{1'b0}}};

    logic signed [COEF_W-1:0] tbl [0:N_ENT-1];
    logic signed [COEF_W-1:0] res [0:1];
    logic [IDX_W-1:0]         off;

    assign off = angle_i[ANGLE_W-3 -: IDX_W];

    // Table contents computed at elaboration, one entry per index.
    for (genvar i = 0; i < N_ENT; i++) begin : g_tbl
        localparam int CODE = park_pkg::quarter_sine_code(i, IDX_W, COEF_W);
        assign tbl[i] = COEF_W'(CODE);
    end

    // Channel 0 is sine, channel 1 is cosine (one quadrant ahead).
    for (genvar ch = 0; ch < 2; ch++) begin : g_fold
        logic [1:0]               quad;
        logic [IDX_W:0]           idx;
        logic signed [COEF_W-1:0] mag;
        assign quad = angle_i[ANGLE_W-1 -: 2] + 2'(ch);
        // Mirror the index in odd quadrants, negate in the lower half turn.
        always_comb begin
            idx     = quad[0] ? (N_IDX - {1'b0, off}) : {1'b0, off};
            mag     = tbl[idx];
            res[ch] = quad[1] ? -mag : mag;
        end
    end

    if (LOW_W > 0) begin : g_low
        logic unused_low;
        assign unused_low = ^angle_i[LOW_W-1:0];
    end

    assign sin_o = res[0];
    assign cos_o = res[1];

endmodule

// File: rtl/park_angle_ctrl.sv
// Module: strobe/busy handshake and factor holding registers.
// Captures the angle on a detected strobe rise, starts a fixed-length
// conversion on the following fall, and loads sine and cosine together on
// the last busy cycle. Rises seen during busy are dropped.
// Assumes strobe_i is synchronous to clk and CONV_CYCLES >= 1.
module park_angle_ctrl #(
    parameter int ANGLE_W     = 12,
    parameter int COEF_W      = 16,
    parameter int CONV_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe_i,
    input  logic [ANGLE_W-1:0]       angle_i,
    input  logic signed [COEF_W-1:0] sin_tab_i,
    input  logic signed [COEF_W-1:0] cos_tab_i,
    output logic [ANGLE_W-1:0]       angle_lat_o,
    output logic                     busy_o,
    output logic signed [COEF_W-1:0] sin_o,
    output logic signed [COEF_W-1:0] cos_o
);
    import park_pkg::*;

    localparam int CW = $clog2(CONV_CYCLES + 1);
    localparam logic signed [COEF_W-1:0] ONE = COEF_W'(1 << (COEF_W - 2));

    ctrl_state_t   state;
    logic          stb_q;
    logic [CW-1:0] cnt;
    logic          stb_rise;
    logic          stb_fall;

    assign stb_rise = strobe_i & ~stb_q;
    assign stb_fall = ~strobe_i & stb_q;
    assign busy_o   = (state == CT_BUSY);

    // Handshake sequencing, angle latch and simultaneous factor load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= CT_IDLE;
            stb_q       <= 1'b0;
            cnt         <= '0;
            angle_lat_o <= '0;
            sin_o       <= '0;
            cos_o       <= ONE;
        end else begin
            stb_q <= strobe_i;
            case (state)
                CT_IDLE: begin
                    if (stb_rise) begin
                        angle_lat_o <= angle_i;
                        state       <= CT_ARMED;
                    end
                end
                CT_ARMED: begin
                    if (stb_fall) begin
                        cnt   <= CW'(CONV_CYCLES);
                        state <= CT_BUSY;
                    end
                end
                CT_BUSY: begin
                    if (cnt == CW'(1)) begin
                        sin_o <= sin_tab_i;
                        cos_o <= cos_tab_i;
                        state <= CT_IDLE;
                    end else begin
                        cnt <= cnt - CW'(1);
                    end
                end
                default: state <= CT_IDLE;
            endcase
        end
    end

    // R5
    strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stb_rise) |=> $stable(angle_lat_o));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CT_ARMED && stb_fall) |=> busy_o);

    // R4
    factor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy_o) |-> ($stable(sin_o) && $stable(cos_o)));

endmodule

// File: rtl/park_rotate_mac.sv
// Module: one-stage rotation of a sample pair by held factors.
// Forms both cross sums at full width, rounds half up by the factor's
// fraction bits and clamps to the sample range. Registered output.
// Assumes factors use COEF_W-2 fraction bits.
module park_rotate_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic signed [DATA_W-1:0] d_i,
    input  logic signed [DATA_W-1:0] q_i,
    input  logic signed [COEF_W-1:0] sin_i,
    input  logic signed [COEF_W-1:0] cos_i,
    output logic signed [DATA_W-1:0] d_o,
    output logic signed [DATA_W-1:0] q_o,
    output logic                     valid_o
);
    localparam int SW   = DATA_W + COEF_W + 1;
    localparam int FRAC = COEF_W - 2;
    localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = -(SW'(1) <<< (DATA_W - 1));
    localparam logic signed [COEF_W-1:0] ONE = COEF_W'(1 << FRAC);

    logic signed [SW-1:0]     dx, qx, sx, cx;
    logic signed [SW-1:0]     sum_d, sum_q, rnd_d, rnd_q;
    logic signed [DATA_W-1:0] sat_d, sat_q;

    assign dx = SW'(d_i);
    assign qx = SW'(q_i);
    assign sx = SW'(sin_i);
    assign cx = SW'(cos_i);

    // Full-width cross products and their sums.
    always_comb begin
        sum_d = dx * cx - qx * sx;
        sum_q = dx * sx + qx * cx;
        rnd_d = (sum_d + HALF) >>> FRAC;
        rnd_q = (sum_q + HALF) >>> FRAC;
    end

    // Clamp each rounded sum into the sample range.
    always_comb begin
        if (rnd_d > MAXV)      sat_d = MAXV[DATA_W-1:0];
        else if (rnd_d < MINV) sat_d = MINV[DATA_W-1:0];
        else                   sat_d = rnd_d[DATA_W-1:0];
        if (rnd_q > MAXV)      sat_q = MAXV[DATA_W-1:0];
        else if (rnd_q < MINV) sat_q = MINV[DATA_W-1:0];
        else                   sat_q = rnd_q[DATA_W-1:0];
    end

    // Output register with qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_o     <= '0;
            q_o     <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= en_i;
            if (en_i) begin
                d_o <= sat_d;
                q_o <= sat_q;
            end
        end
    end

    // R6
    identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && sin_i == '0 && cos_i == ONE) |=> (d_o == $past(d_i) && q_o == $past(q_i)));

endmodule

// File: rtl/park_rotator.sv
// Module: top of the angle-strobed rotator. Ties the handshake, the table
// lookup on the latched angle and the rotation stage together, and gates
// input samples while the strobe is high or a conversion is running.
// Assumes all inputs are synchronous to clk.
module park_rotator #(
    parameter int ANGLE_W     = 12,
    parameter int DATA_W      = 16,
    parameter int COEF_W      = 16,
    parameter int IDX_W       = 8,
    parameter int CONV_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     strobe_i,
    input  logic [ANGLE_W-1:0]       angle_i,
    input  logic                     in_valid_i,
    input  logic signed [DATA_W-1:0] d_i,
    input  logic signed [DATA_W-1:0] q_i,
    output logic                     busy_o,
    output logic                     out_valid_o,
    output logic signed [DATA_W-1:0] d_o,
    output logic signed [DATA_W-1:0] q_o
);
    logic [ANGLE_W-1:0]       angle_lat;
    logic signed [COEF_W-1:0] sin_tab, cos_tab, sin_f, cos_f;
    logic                     accept;

    assign accept = in_valid_i & ~busy_o & ~strobe_i;

    park_angle_ctrl #(
        .ANGLE_W(ANGLE_W), .COEF_W(COEF_W), .CONV_CYCLES(CONV_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .angle_i(angle_i),
        .sin_tab_i(sin_tab), .cos_tab_i(cos_tab), .angle_lat_o(angle_lat),
        .busy_o(busy_o), .sin_o(sin_f), .cos_o(cos_f)
    );

    park_sincos_lut #(
        .ANGLE_W(ANGLE_W), .IDX_W(IDX_W), .COEF_W(COEF_W)
    ) u_lut (
        .angle_i(angle_lat), .sin_o(sin_tab), .cos_o(cos_tab)
    );

    park_rotate_mac #(
        .DATA_W(DATA_W), .COEF_W(COEF_W)
    ) u_mac (
        .clk(clk), .rst_n(rst_n), .en_i(accept), .d_i(d_i), .q_i(q_i),
        .sin_i(sin_f), .cos_i(cos_f), .d_o(d_o), .q_o(q_o), .valid_o(out_valid_o)
    );

    // R9
    out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o || strobe_i) |=> !out_valid_o);

endmodule

// File: tb/park_rotator_tb.sv
module park_rotator_tb;
    localparam int CONV  = 6;
    localparam int FRAC  = 14;
    localparam int SHIFT = 2;
    localparam real PI   = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe = 1'b0;
    logic [11:0] angle = '0;
    logic in_valid = 1'b0;
    logic signed [15:0] d_in = '0, q_in = '0;
    logic busy, out_valid;
    logic signed [15:0] d_out, q_out;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    always #4 clk = ~clk;

    park_rotator #(.CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .angle_i(angle),
        .in_valid_i(in_valid), .d_i(d_in), .q_i(q_in), .busy_o(busy),
        .out_valid_o(out_valid), .d_o(d_out), .q_o(q_out)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    task automatic chk(string req, longint act, longint exp, int tol = 0);
        longint diff;
        checks++;
        diff = act - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint coef(int ang, bit use_cos);
        int  aq;
        real phi, v, m;
        aq  = (ang >> SHIFT) << SHIFT;
        phi = 2.0 * PI * real'(aq) / 4096.0;
        v   = use_cos ? $cos(phi) : $sin(phi);
        m   = $floor((v < 0.0 ? -v : v) * 16384.0 + 0.5);
        return v < 0.0 ? -longint'(m) : longint'(m);
    endfunction

    function automatic longint rsat(longint s);
        longint r;
        r = (s + 8192) >>> FRAC;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    function automatic longint exp_d(longint d, longint q, int ang);
        return rsat(d * coef(ang, 1'b1) - q * coef(ang, 1'b0));
    endfunction

    function automatic longint exp_q(longint d, longint q, int ang);
        return rsat(d * coef(ang, 1'b0) + q * coef(ang, 1'b1));
    endfunction

    // Full strobe pulse; angle is scrambled after the rise. Ends at the negedge busy is low.
    task automatic load_angle(int ang, output int busy_cycles);
        angle  = 12'(ang);
        strobe = 1'b1;
        @(negedge clk);
        angle  = ~12'(ang);
        strobe = 1'b0;
        busy_cycles = 0;
        @(negedge clk);
        while (busy && busy_cycles < 100) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic stream(int d, int q, output int od, output int oq, output bit ov);
        in_valid = 1'b1;
        d_in = 16'(d);
        q_in = 16'(q);
        @(negedge clk);
        in_valid = 1'b0;
        od = d_out;
        oq = q_out;
        ov = out_valid;
    endtask

    task automatic t_reset();
        int od, oq;
        bit ov;
        chk("R1 busy after reset", busy, 0);
        chk("R1 valid after reset", out_valid, 0);
        stream(1000, -2000, od, oq, ov);
        chk("R9 valid one cycle later", ov, 1);
        chk("R1 identity d", od, 1000);
        chk("R1 identity q", oq, -2000);
        @(negedge clk);
        chk("R9 valid drops", out_valid, 0);
    endtask

    task automatic t_timing();
        int bc, od, oq;
        bit ov;
        load_angle(683, bc);
        chk("R3 busy length", bc, CONV);
        stream(10000, 0, od, oq, ov);
        chk("R2 latched angle d", od, exp_d(10000, 0, 683), 1);
        chk("R2 latched angle q", oq, exp_q(10000, 0, 683), 1);
    endtask

    task automatic t_pair();
        int bc, od, oq;
        bit ov;
        load_angle(0, bc);
        load_angle(1024, bc);
        stream(3000, 700, od, oq, ov);
        chk("R4 new pair d", od, -700);
        chk("R4 new pair q", oq, 3000);
    endtask

    task automatic t_quadrants();
        int bc, od, oq;
        bit ov;
        load_angle(2048, bc);
        stream(3000, 700, od, oq, ov);
        chk("R7 180 d", od, -3000);
        chk("R7 180 q", oq, -700);
        load_angle(3072, bc);
        stream(3000, 700, od, oq, ov);
        chk("R7 270 d", od, 700);
        chk("R7 270 q", oq, -3000);
        load_angle(1024, bc);
        stream(-1234, 4321, od, oq, ov);
        chk("R7 90 d", od, -4321);
        chk("R7 90 q", oq, -1234);
    endtask

    task automatic t_saturation();
        int bc, od, oq;
        bit ov;
        load_angle(1024, bc);
        stream(5, -32768, od, oq, ov);
        chk("R8 clamp at 90 d", od, 32767);
        chk("R8 clamp at 90 q", oq, 5);
        load_angle(2048, bc);
        stream(-32768, 100, od, oq, ov);
        chk("R8 clamp at 180 d", od, 32767);
        chk("R8 clamp at 180 q", oq, -100);
        load_angle(512, bc);
        stream(32767, 32767, od, oq, ov);
        chk("R8 45 deg d", od, exp_d(32767, 32767, 512));
        chk("R8 45 deg q clamp", oq, 32767);
        stream(-1, 0, od, oq, ov);
        chk("R8 round small d", od, exp_d(-1, 0, 512));
        chk("R8 round small q", oq, exp_q(-1, 0, 512));
    endtask

    task automatic t_generic();
        int bc, od, oq;
        bit ov;
        int angs[3] = '{300, 1777, 3900};
        foreach (angs[k]) begin
            load_angle(angs[k], bc);
            stream(12345, -6789, od, oq, ov);
            chk("R6 rotate d", od, exp_d(12345, -6789, angs[k]), 1);
            chk("R6 rotate q", oq, exp_q(12345, -6789, angs[k]), 1);
            stream(-20000, 15000, od, oq, ov);
            chk("R6 rotate d2", od, exp_d(-20000, 15000, angs[k]), 1);
            chk("R6 rotate q2", oq, exp_q(-20000, 15000, angs[k]), 1);
        end
    endtask

    task automatic t_quant();
        int bc, od, oq;
        bit ov;
        load_angle(1027, bc);
        stream(20000, -9000, od, oq, ov);
        chk("R10 low bits ignored d", od, 9000);
        chk("R10 low bits ignored q", oq, 20000);
    endtask

    task automatic t_ignore();
        int od, oq, again;
        bit ov;
        angle = 12'd2048;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        angle = 12'd1024;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        while (busy) @(negedge clk);
        again = 0;
        for (int k = 0; k < CONV + 2; k++) begin
            if (busy) again++;
            @(negedge clk);
        end
        chk("R5 no second conversion", again, 0);
        stream(3000, 700, od, oq, ov);
        chk("R5 pending angle kept d", od, -3000);
        chk("R5 pending angle kept q", oq, -700);
    endtask

    task automatic t_gating();
        int od, oq;
        bit ov;
        angle = 12'd0;
        strobe = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R9 gated by strobe", out_valid, 0);
        strobe = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 gated by busy", out_valid, 0);
        in_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R9 idle no valid", out_valid, 0);
        stream(-555, 777, od, oq, ov);
        chk("R9 valid after load", ov, 1);
        chk("R6 identity d after reload", od, -555);
        chk("R6 identity q after reload", oq, 777);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_pair();
        t_quadrants();
        t_saturation();
        t_generic();
        t_quant();
        t_ignore();
        t_gating();
        report();
        $finish;
    end

endmodule